// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

The block is an 8-bit binary down-counter that is stepped by one of four slow tick enables (nominally 4096 Hz, 64 Hz, 1 Hz and one tick per minute). A two-bit select chooses which tick is used. Software writes a reload value. The counter then counts that many ticks of the chosen source, raises a sticky timer flag, reloads and starts again. A reload value of zero parks the counter. The live count can be read back at any time.

An active-low interrupt is built from the flag in one of two modes. In level mode the interrupt is asserted while the flag is set. In pulse mode it gives one low pulse at each expiry, and the pulse length depends on the source and on whether the reload value is one. Pulse lengths are measured in ticks of an 8192 Hz reference enable from the same clock domain. The tick enables come from a prescaler outside the block. All configuration arrives on plain control pins.

Top module: `tick_countdown_timer`

## Requirements
- R1: After reset, count_q is 0, flag_q is 0 and irq_n is 1.
- R2: A cycle with ld_valid high loads ld_value into both the reload value and the live count, so count_q shows it after that clock edge. A load in the same cycle as a selected tick takes priority, and that tick is dropped.
- R3: With cfg_run high and a nonzero reload value n, each selected tick decrements count_q. A tick that arrives while count_q is 1 reloads n and marks an expiry. For n = 3 the count reads 3, 2, 1, 3.
- R4: cfg_src selects the stepping tick: 00 = tick_4k, 01 = tick_64, 10 = tick_1, 11 = tick_min. Ticks on the unselected inputs leave count_q unchanged.
- R5: With cfg_run low, count_q holds. With a reload value of 0, ticks leave count_q at 0 and never set the flag.
- R6: Every expiry sets flag_q. A cycle with flag_wr high and flag_wdata 0 clears it. flag_wdata 1 leaves it unchanged. If an expiry and a clear fall in the same cycle, the flag ends up set.
- R7: With cfg_pulse 0, irq_n is low exactly while flag_q is 1 and cfg_ie is 1.
- R8: With cfg_pulse 1, irq_n goes low together with the flag at each expiry and ignores the flag afterwards. With cfg_ie 0, irq_n stays high.
- R9: The pulse-mode low time, counted in tick_ref pulses after the expiry edge, is: source 00 with n = 1: 1; source 00 with n > 1: 2; source 01 with n = 1: 64; source 01 with n > 1: 128; sources 10 and 11: 128. irq_n returns high on the edge that takes in the last of these reference ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_4k | input | 1 | 4096 Hz tick enable |
| tick_64 | input | 1 | 64 Hz tick enable |
| tick_1 | input | 1 | 1 Hz tick enable |
| tick_min | input | 1 | One-per-minute tick enable |
| tick_ref | input | 1 | 8192 Hz reference enable used to time pulses |
| cfg_run | input | 1 | Counting enable |
| cfg_src | input | 2 | Source tick select |
| cfg_pulse | input | 1 | Interrupt mode: 0 level, 1 pulse |
| cfg_ie | input | 1 | Interrupt enable |
| ld_valid | input | 1 | Write strobe for the count register |
| ld_value | input | 8 | Reload value to write |
| flag_wr | input | 1 | Write strobe for the flag |
| flag_wdata | input | 1 | Flag write data (0 clears) |
| count_q | output | 8 | Live countdown value |
| flag_q | output | 1 | Sticky timer flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
An expiry and a software clear of the flag can land on the same clock edge. The bench provokes this by pulsing the selected tick while count_q is 1 and, in the same cycle, writing 0 to the flag. It passes only if flag_q reads 1 afterwards. A second collision, between a count-register write and a selected tick, is provoked in the same way and judged by count_q showing the written value rather than a decremented one.

// File: rtl/tct_pkg.sv
package tct_pkg;
  typedef enum logic [1:0] {
    SRC_4K  = 2'b00,
    SRC_64  = 2'b01,
    SRC_1   = 2'b10,
    SRC_MIN = 2'b11
  } tct_src_e;
  localparam int N_SRC = 4;
endpackage

// File: rtl/tct_src_sel.sv
module tct_src_sel #(
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  ticks,
  input  logic [SW-1:0] sel,
  output logic          src_tick
);
  always_comb src_tick = ticks[sel];
endmodule

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          src_tick,
  input  logic          ld_valid,
  input  logic [CW-1:0] ld_value,
  output logic [CW-1:0] count_q,
  output logic [CW-1:0] reload_q,
  output logic          expire
);
  logic step;
  always_comb begin
    step   = run && src_tick && !ld_valid && (reload_q != '0);
    expire = step && (count_q <= CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
    end else if (ld_valid) begin
      count_q  <= ld_value;
      reload_q <= ld_value;
    end else if (expire) begin
      count_q  <= reload_q;
    end else if (step) begin
      count_q  <= count_q - CW'(1);
    end
  end
endmodule

// File: rtl/tct_irq.sv
module tct_irq
  import tct_pkg::*;
#(
  parameter int CW = 8,
  parameter int REF_PER_64HZ = 128,
  localparam int PW = $clog2(REF_PER_64HZ + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expire,
  input  logic [1:0]    src,
  input  logic [CW-1:0] reload,
  input  logic          ref_tick,
  input  logic          pulse_mode,
  input  logic          irq_en,
  input  logic          flag_wr,
  input  logic          flag_wdata,
  output logic          flag_q,
  output logic          irq_n
);
  localparam logic [PW-1:0] W_8K  = PW'(1);
  localparam logic [PW-1:0] W_4K  = PW'(REF_PER_64HZ / 64);
  localparam logic [PW-1:0] W_128 = PW'(REF_PER_64HZ / 2);
  localparam logic [PW-1:0] W_64  = PW'(REF_PER_64HZ);

  logic [PW-1:0] width;
  logic [PW-1:0] pulse_cnt;
  logic          single;

  always_comb begin
    single = (reload == CW'(1));
    unique case (tct_src_e'(src))
      SRC_4K:  width = single ? W_8K : W_4K;
      SRC_64:  width = single ? W_128 : W_64;
      default: width = W_64;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      if (expire)                     flag_q <= 1'b1;
      else if (flag_wr && !flag_wdata) flag_q <= 1'b0;

      if (expire)                             pulse_cnt <= width;
      else if (ref_tick && pulse_cnt != '0) pulse_cnt <= pulse_cnt - PW'(1);
    end
  end

  always_comb begin
    if (pulse_mode) irq_n = !(irq_en && (pulse_cnt != '0));
    else            irq_n = !(irq_en && flag_q);
  end
endmodule

// File: rtl/tick_countdown_timer.sv
module tick_countdown_timer
  import tct_pkg::*;
#(
  parameter int CW = 8,
  parameter int REF_PER_64HZ = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_4k,
  input  logic          tick_64,
  input  logic          tick_1,
  input  logic          tick_min,
  input  logic          tick_ref,
  input  logic          cfg_run,
  input  logic [1:0]    cfg_src,
  input  logic          cfg_pulse,
  input  logic          cfg_ie,
  input  logic          ld_valid,
  input  logic [CW-1:0] ld_value,
  input  logic          flag_wr,
  input  logic          flag_wdata,
  output logic [CW-1:0] count_q,
  output logic          flag_q,
  output logic          irq_n
);
  logic          sel_tick;
  logic          expire;
  logic [CW-1:0] reload;

  tct_src_sel #(.N(N_SRC)) u_sel (
    .ticks    ({tick_min, tick_1, tick_64, tick_4k}),
    .sel      (cfg_src),
    .src_tick (sel_tick)
  );

  tct_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cfg_run),
    .src_tick (sel_tick),
    .ld_valid (ld_valid),
    .ld_value (ld_value),
    .count_q  (count_q),
    .reload_q (reload),
    .expire   (expire)
  );

  tct_irq #(.CW(CW), .REF_PER_64HZ(REF_PER_64HZ)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .src        (cfg_src),
    .reload     (reload),
    .ref_tick   (tick_ref),
    .pulse_mode (cfg_pulse),
    .irq_en     (cfg_ie),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .flag_q     (flag_q),
    .irq_n      (irq_n)
  );
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_4k,
  input logic          tick_64,
  input logic          tick_1,
  input logic          tick_min,
  input logic          cfg_run,
  input logic [1:0]    cfg_src,
  input logic          cfg_pulse,
  input logic          cfg_ie,
  input logic          ld_valid,
  input logic [CW-1:0] ld_value,
  input logic          flag_wr,
  input logic          flag_wdata,
  input logic [CW-1:0] count_q,
  input logic          flag_q,
  input logic          irq_n
);
  logic [3:0] tvec;
  logic       picked;
  always_comb begin
    tvec   = {tick_min, tick_1, tick_64, tick_4k};
    picked = tvec[cfg_src];
  end

  a_r2_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> count_q == $past(ld_value));

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_run && picked && !ld_valid && count_q > CW'(1)) |=> count_q == $past(count_q) - CW'(1));

  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_run && !ld_valid) |=> $stable(count_q));

  a_r6_set_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_run && picked && !ld_valid && count_q == CW'(1)) |=> flag_q);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(flag_wr && !flag_wdata)) |=> flag_q);

  a_r7_level_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pulse && (!cfg_ie || !flag_q)) |-> irq_n);

  a_r8_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pulse && !cfg_ie) |-> irq_n);
endmodule

bind tick_countdown_timer tct_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_4k(tick_4k), .tick_64(tick_64),
  .tick_1(tick_1), .tick_min(tick_min), .cfg_run(cfg_run), .cfg_src(cfg_src),
  .cfg_pulse(cfg_pulse), .cfg_ie(cfg_ie), .ld_valid(ld_valid), .ld_value(ld_value),
  .flag_wr(flag_wr), .flag_wdata(flag_wdata), .count_q(count_q), .flag_q(flag_q),
  .irq_n(irq_n)
);

// File: tb/tick_countdown_timer_tb_top.sv
module tick_countdown_timer_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 10;
  // {ticks(4k,64,1,min), src, exp_flag, 1'b0, exp_count}
  localparam logic [15:0] VEC [NV] = '{
    {4'b1000, 2'd0, 1'b0, 1'b0, 8'd2},
    {4'b0100, 2'd0, 1'b0, 1'b0, 8'd2},
    {4'b1000, 2'd0, 1'b0, 1'b0, 8'd1},
    {4'b1000, 2'd0, 1'b1, 1'b0, 8'd3},
    {4'b1000, 2'd1, 1'b1, 1'b0, 8'd3},
    {4'b0100, 2'd1, 1'b1, 1'b0, 8'd2},
    {4'b0100, 2'd2, 1'b1, 1'b0, 8'd2},
    {4'b0010, 2'd2, 1'b1, 1'b0, 8'd1},
    {4'b0010, 2'd3, 1'b1, 1'b0, 8'd1},
    {4'b0001, 2'd3, 1'b1, 1'b0, 8'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_4k = 0, tick_64 = 0, tick_1 = 0, tick_min = 0, tick_ref = 0;
  logic cfg_run = 0, cfg_pulse = 0, cfg_ie = 0;
  logic [1:0] cfg_src = 2'd0;
  logic ld_valid = 0;
  logic [7:0] ld_value = 8'd0;
  logic flag_wr = 0, flag_wdata = 0;
  logic [7:0] count_q;
  logic flag_q, irq_n;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tick_countdown_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_4k(tick_4k), .tick_64(tick_64),
    .tick_1(tick_1), .tick_min(tick_min), .tick_ref(tick_ref),
    .cfg_run(cfg_run), .cfg_src(cfg_src), .cfg_pulse(cfg_pulse), .cfg_ie(cfg_ie),
    .ld_valid(ld_valid), .ld_value(ld_value), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .count_q(count_q), .flag_q(flag_q), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ticks(input logic [3:0] t);
    {tick_4k, tick_64, tick_1, tick_min} = t;
  endtask

  task automatic load(input logic [7:0] v);
    ld_valid = 1; ld_value = v;
    cyc();
    ld_valid = 0;
  endtask

  task automatic clear_flag();
    flag_wr = 1; flag_wdata = 0;
    cyc();
    flag_wr = 0;
  endtask

  task automatic src_tick(input logic [1:0] s);
    set_ticks(4'b1000 >> s);
    cyc();
    set_ticks(4'b0000);
  endtask

  task automatic pulse_case(input logic [1:0] s, input logic [7:0] n, input int exp_w);
    int w;
    clear_flag();
    cfg_src = s;
    load(n);
    for (int i = 0; i < n; i++) src_tick(s);
    chk("R8 pulse asserted at expiry", irq_n, 0);
    w = 0;
    while (irq_n == 1'b0 && w < 300) begin
      tick_ref = 1;
      cyc();
      w++;
    end
    tick_ref = 0;
    chk($sformatf("R9 pulse width src=%0d n=%0d", s, n), w, exp_w);
    chk("R8 pulse ends while flag stays set", {flag_q, irq_n}, 3);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    // R1 reset state
    chk("R1 count after reset", count_q, 0);
    chk("R1 flag after reset", flag_q, 0);
    chk("R1 irq after reset", irq_n, 1);

    cfg_run = 1; cfg_src = 2'd0;
    load(8'd3);
    chk("R2 load shows value", count_q, 3);

    // R3/R4/R6 vector walk
    for (int k = 0; k < NV; k++) begin
      cfg_src = VEC[k][11:10];
      set_ticks(VEC[k][15:12]);
      cyc();
      set_ticks(4'b0000);
      chk($sformatf("R3 R4 vector %0d count", k), count_q, VEC[k][7:0]);
      chk($sformatf("R6 vector %0d flag", k), flag_q, VEC[k][9]);
    end

    // R2 load beats a same-cycle tick
    cfg_src = 2'd0;
    ld_valid = 1; ld_value = 8'd5; tick_4k = 1;
    cyc();
    ld_valid = 0; tick_4k = 0;
    chk("R2 load wins over tick", count_q, 5);

    // R6 flag writes
    flag_wr = 1; flag_wdata = 1;
    cyc();
    flag_wr = 0;
    chk("R6 write 1 keeps flag", flag_q, 1);
    clear_flag();
    chk("R6 write 0 clears flag", flag_q, 0);

    // R7 level mode
    cfg_ie = 1; cfg_pulse = 0;
    chk("R7 level idle", irq_n, 1);
    load(8'd1);
    src_tick(2'd0);
    chk("R7 level asserted", irq_n, 0);
    cfg_ie = 0;
    cyc();
    chk("R7 level masked", irq_n, 1);

    // R6 expiry and clear in the same cycle
    clear_flag();
    flag_wr = 1; flag_wdata = 0; tick_4k = 1;
    cyc();
    flag_wr = 0; tick_4k = 0;
    chk("R6 set wins over clear", flag_q, 1);

    // R5 hold when stopped, and zero reload
    load(8'd2);
    cfg_run = 0;
    src_tick(2'd0);
    chk("R5 run low holds count", count_q, 2);
    cfg_run = 1;
    clear_flag();
    load(8'd0);
    for (int i = 0; i < 3; i++) src_tick(2'd0);
    chk("R5 zero reload count", count_q, 0);
    chk("R5 zero reload no flag", flag_q, 0);

    // R8 pulse mode masked
    cfg_pulse = 1; cfg_ie = 0;
    load(8'd1);
    src_tick(2'd0);
    chk("R8 masked pulse flag", flag_q, 1);
    chk("R8 masked pulse irq", irq_n, 1);

    // R9 pulse widths
    cfg_ie = 1;
    pulse_case(2'd0, 8'd1, 1);
    pulse_case(2'd0, 8'd2, 2);
    pulse_case(2'd1, 8'd1, 64);
    pulse_case(2'd1, 8'd3, 128);
    pulse_case(2'd2, 8'd1, 128);
    pulse_case(2'd3, 8'd2, 128);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule